// File: doc/BRIEF.md
# Serial Flash User-Transfer Engine

This block is an SPI master aimed at serial flash parts. Software drives it through a small 32-bit word-addressed register window. It fills a 64-byte staging buffer, sets a bit count and a few phase options, and clears the sticky completion flag. It then writes the start bit and polls the flag until the transfer is over. While bits shift out on MOSI, the engine can sample MISO and write each received bit over the bit it just sent. After a full-duplex transfer the buffer therefore holds the reply in place.

The serial link runs in SPI mode 0. SCLK rests low, MOSI moves only on falling SCLK edges, and MISO is taken on rising edges. Each SCLK half period lasts a programmable number of system clocks. There is one chip select. A hold option keeps it asserted between transfers, so a single flash command can be spread over several buffer loads. A soft reset aborts any transfer and releases the pins. A memory-mapped read path outside this block is represented only by an enable level, which is forced low while a transfer runs.

The register bus has no back-pressure. A write is taken on every clock edge where `bus_we` is high. Read data is a combinational function of `bus_widx`. Word indices 0 to 15 hold control registers. Indices 16 to 31 hold the buffer, which sits in the upper half of the window.

Top module: `spi_user_engine`

## Requirements
- R1: After reset, cs_n is 1, SCLK and MOSI are 0 and mmap_en is 1. Word 12 reads with bit 4 (done) set and bit 31 clear. Word 0 bit 18 (busy) reads 0. Word 7 bit 2 (compat) reads 1. Word 6 reads 1 and word 8 reads 7 << 17.
- R2: Buffer word k sits at word index 16 + k and reads back what was written. Stream byte 4k+j occupies bits [8j+7:8j] of that word.
- R3: Writing word 0 with bit 18 set starts a transfer. The transfer sends (word 8 bits [25:17]) + 1 bits, each byte MSB first, starting with stream byte 0. If word 7 bit 27 (output phase) is clear, the start only sets done on the next edge and SCLK never moves.
- R4: SCLK is 0 whenever no transfer runs. Each SCLK level lasts (word 6 bits [5:0]) + 1 clocks, beginning with a low level. MOSI changes only when SCLK falls.
- R5: With word 7 bit 0 set, the MISO value taken at each rising SCLK edge replaces the buffer bit that was sent in that slot. With bit 0 clear, the buffer is left unchanged.
- R6: Word 12 bit 4 sets on the edge that ends a transfer. A write to word 12 with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it as it was.
- R7: A start is ignored while a transfer runs, while soft reset runs, or while done is set.
- R8: cs_n falls when a transfer starts. When the last bit's SCLK falls, cs_n goes high if word 11 bit 30 is 0 and stays low if it is 1.
- R9: Writing word 12 with bit 31 set aborts any transfer at once, driving cs_n 1 and SCLK and MOSI 0. Bit 31 then reads 1 for 4 clocks, after which done sets.
- R10: mmap_en equals word 2 bit 17 (reset value 1) while idle and is 0 while a transfer runs.
- R11: While a transfer runs, writes to the buffer and to every control word except word 12 are dropped.
- R12: Word 12 bit 30 (mode) and word 7 bit 2 read back as written. Word indices 1, 3, 4, 5, 9, 10, 13, 14 and 15 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe, accepted every cycle |
| bus_widx | input | 5 | Word index for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_widx |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| mmap_en | output | 1 | Memory-mapped read path enable |

## Verification
The bench targets four kinds of corner case.

- Bit counts that stop partway through a byte. A design that rounds up to whole bytes, or maps bits to the wrong byte lane, sends the wrong MOSI bits or overwrites the wrong buffer bits.
- Starts in the wrong state: while busy, with done still set, and with the output phase switched off. Getting these wrong shows up as stray SCLK activity or a done flag that never rises.
- Soft reset in the middle of a transfer. Here the buffer must keep exactly the bits already received.
- Chip-select hold across back-to-back transfers, and buffer or length writes issued mid-transfer. A design that lets those writes land corrupts the data still being sent.

// File: rtl/spiu_pkg.sv
package spiu_pkg;
  // control word indices within the register window
  localparam int WI_OP    = 0;
  localparam int WI_PATH  = 2;
  localparam int WI_CLK   = 6;
  localparam int WI_PHASE = 7;
  localparam int WI_LEN   = 8;
  localparam int WI_HOLD  = 11;
  localparam int WI_CTL   = 12;

  // field positions
  localparam int B_START  = 18;
  localparam int B_MAPEN  = 17;
  localparam int B_OUTSEL = 27;
  localparam int B_RXEN   = 0;
  localparam int B_COMPAT = 2;
  localparam int B_LEN    = 17;
  localparam int B_HOLD   = 30;
  localparam int B_DONE   = 4;
  localparam int B_MODE   = 30;
  localparam int B_SRST   = 31;

  localparam int DIV_W = 6;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_RST  = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic             out_sel;
    logic             rx_en;
    logic             compat;
    logic             hold;
    logic             map_en;
    logic             mode;
    logic [DIV_W-1:0] half_div;
  } cfg_t;
endpackage

// File: rtl/spiu_regs.sv
module spiu_regs
  import spiu_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wdata,
  input  logic             busy,
  output cfg_t             cfg,
  output logic [LEN_W-1:0] nbits_m1,
  output logic             start_pulse,
  output logic             srst_pulse,
  output logic             done_clr
);
  logic reg_we;
  logic unused_wdata;

  assign reg_we       = wr_en & ~wr_idx[IDX_W-1];
  assign unused_wdata = ^wdata;

  assign start_pulse = reg_we && (wr_idx == IDX_W'(WI_OP)) && wdata[B_START];
  assign srst_pulse  = reg_we && (wr_idx == IDX_W'(WI_CTL)) && wdata[B_SRST];
  assign done_clr    = reg_we && (wr_idx == IDX_W'(WI_CTL)) && !wdata[B_DONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.out_sel  <= 1'b0;
      cfg.rx_en    <= 1'b0;
      cfg.compat   <= 1'b1;
      cfg.hold     <= 1'b0;
      cfg.map_en   <= 1'b1;
      cfg.mode     <= 1'b0;
      cfg.half_div <= DIV_W'(1);
      nbits_m1     <= LEN_W'(7);
    end else if (reg_we) begin
      if (wr_idx == IDX_W'(WI_CTL)) cfg.mode <= wdata[B_MODE];
      if (!busy) begin
        if (wr_idx == IDX_W'(WI_PATH)) cfg.map_en <= wdata[B_MAPEN];
        if (wr_idx == IDX_W'(WI_CLK))  cfg.half_div <= wdata[DIV_W-1:0];
        if (wr_idx == IDX_W'(WI_PHASE)) begin
          cfg.out_sel <= wdata[B_OUTSEL];
          cfg.rx_en   <= wdata[B_RXEN];
          cfg.compat  <= wdata[B_COMPAT];
        end
        if (wr_idx == IDX_W'(WI_LEN))  nbits_m1 <= wdata[B_LEN +: LEN_W];
        if (wr_idx == IDX_W'(WI_HOLD)) cfg.hold <= wdata[B_HOLD];
      end
    end
  end
endmodule

// File: rtl/spiu_buffer.sv
module spiu_buffer #(
  parameter int WORDS = 16,
  localparam int WI_W = $clog2(WORDS),
  localparam int BI_W = WI_W + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [WI_W-1:0] bus_widx,
  input  logic [31:0]     bus_wdata,
  input  logic [WI_W-1:0] bus_ridx,
  output logic [31:0]     bus_rword,
  input  logic            eng_we,
  input  logic [BI_W-1:0] eng_widx,
  input  logic            eng_wval,
  input  logic [BI_W-1:0] eng_ridx,
  output logic            eng_rbit
);
  logic [WORDS-1:0][31:0] words;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (bus_we && (bus_widx == WI_W'(w))) begin
        word_q <= bus_wdata;
      end else if (eng_we && (eng_widx[BI_W-1:5] == WI_W'(w))) begin
        word_q[eng_widx[4:0]] <= eng_wval;
      end
    end
    assign words[w] = word_q;
  end

  assign bus_rword = words[bus_ridx];
  assign eng_rbit  = words[eng_ridx[BI_W-1:5]][eng_ridx[4:0]];
endmodule

// File: rtl/spiu_shifter.sv
module spiu_shifter
  import spiu_pkg::*;
#(
  parameter int LEN_W      = 9,
  parameter int RST_CYCLES = 4,
  localparam int RC_W      = $clog2(RST_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic             srst_pulse,
  input  logic             done_clr,
  input  cfg_t             cfg,
  input  logic [LEN_W-1:0] nbits_m1,
  input  logic             miso,
  output logic [LEN_W-1:0] rd_idx,
  input  logic             rd_bit,
  output logic             wr_en,
  output logic [LEN_W-1:0] wr_idx,
  output logic             wr_val,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic             done,
  output logic             busy,
  output logic             srst_busy
);
  eng_state_e       state;
  logic [DIV_W-1:0] cnt;
  logic [LEN_W-1:0] bitpos;
  logic [RC_W-1:0]  rcnt;
  logic             half_end;
  logic             last_bit;
  logic             unused_cfg;

  // stream bit b lives in byte b/8, MSB first within the byte
  function automatic logic [LEN_W-1:0] to_buf(input logic [LEN_W-1:0] b);
    return {b[LEN_W-1:3], ~b[2:0]};
  endfunction

  assign unused_cfg = ^{cfg.compat, cfg.map_en, cfg.mode};
  assign busy       = (state == ENG_RUN);
  assign srst_busy  = (state == ENG_RST);
  assign half_end   = (cnt == cfg.half_div);
  assign last_bit   = (bitpos == nbits_m1);

  assign rd_idx = (state == ENG_IDLE) ? to_buf('0) : to_buf(bitpos + LEN_W'(1));
  assign wr_en  = busy && half_end && !sclk && cfg.rx_en && !srst_pulse;
  assign wr_idx = to_buf(bitpos);
  assign wr_val = miso;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b1;
      cnt    <= '0;
      bitpos <= '0;
      rcnt   <= '0;
    end else begin
      if (done_clr) done <= 1'b0;
      if (srst_pulse) begin
        state  <= ENG_RST;
        rcnt   <= '0;
        sclk   <= 1'b0;
        mosi   <= 1'b0;
        cs_n   <= 1'b1;
        done   <= 1'b0;
        cnt    <= '0;
        bitpos <= '0;
      end else begin
        unique case (state)
          ENG_IDLE: begin
            if (start_pulse && !done) begin
              if (cfg.out_sel) begin
                state  <= ENG_RUN;
                cs_n   <= 1'b0;
                sclk   <= 1'b0;
                cnt    <= '0;
                bitpos <= '0;
                mosi   <= rd_bit;
              end else begin
                done <= 1'b1;
              end
            end
          end
          ENG_RUN: begin
            if (half_end) begin
              cnt <= '0;
              if (!sclk) begin
                sclk <= 1'b1;
              end else begin
                sclk <= 1'b0;
                if (last_bit) begin
                  state <= ENG_IDLE;
                  done  <= 1'b1;
                  cs_n  <= ~cfg.hold;
                  mosi  <= 1'b0;
                end else begin
                  bitpos <= bitpos + LEN_W'(1);
                  mosi   <= rd_bit;
                end
              end
            end else begin
              cnt <= cnt + DIV_W'(1);
            end
          end
          ENG_RST: begin
            if (rcnt == RC_W'(RST_CYCLES - 1)) begin
              state <= ENG_IDLE;
              done  <= 1'b1;
            end else begin
              rcnt <= rcnt + RC_W'(1);
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_user_engine.sv
module spi_user_engine
  import spiu_pkg::*;
#(
  parameter int IDX_W      = 5,
  parameter int RST_CYCLES = 4,
  localparam int WORDS     = 2 ** (IDX_W - 1),
  localparam int LEN_W     = $clog2(WORDS * 32),
  localparam int WI_W      = IDX_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_widx,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n,
  output logic             mmap_en
);
  cfg_t             cfg;
  logic [LEN_W-1:0] nbits_m1;
  logic             start_pulse, srst_pulse, done_clr;
  logic             busy_w, done_w, srst_busy_w;
  logic [LEN_W-1:0] eng_ridx, eng_widx;
  logic             eng_rbit, eng_we, eng_wval;
  logic [31:0]      buf_word;
  logic             is_buf;

  assign is_buf = bus_widx[IDX_W-1];

  spiu_regs #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_idx(bus_widx),
    .wdata(bus_wdata), .busy(busy_w), .cfg(cfg), .nbits_m1(nbits_m1),
    .start_pulse(start_pulse), .srst_pulse(srst_pulse), .done_clr(done_clr)
  );

  spiu_buffer #(.WORDS(WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we && is_buf && !busy_w),
    .bus_widx(bus_widx[WI_W-1:0]), .bus_wdata(bus_wdata),
    .bus_ridx(bus_widx[WI_W-1:0]), .bus_rword(buf_word),
    .eng_we(eng_we), .eng_widx(eng_widx), .eng_wval(eng_wval),
    .eng_ridx(eng_ridx), .eng_rbit(eng_rbit)
  );

  spiu_shifter #(.LEN_W(LEN_W), .RST_CYCLES(RST_CYCLES)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .srst_pulse(srst_pulse), .done_clr(done_clr), .cfg(cfg),
    .nbits_m1(nbits_m1), .miso(spi_miso), .rd_idx(eng_ridx),
    .rd_bit(eng_rbit), .wr_en(eng_we), .wr_idx(eng_widx),
    .wr_val(eng_wval), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .done(done_w), .busy(busy_w), .srst_busy(srst_busy_w)
  );

  assign mmap_en = cfg.map_en & ~busy_w;

  always_comb begin
    bus_rdata = '0;
    if (is_buf) begin
      bus_rdata = buf_word;
    end else if (bus_widx == IDX_W'(WI_OP)) begin
      bus_rdata[B_START] = busy_w;
    end else if (bus_widx == IDX_W'(WI_PATH)) begin
      bus_rdata[B_MAPEN] = cfg.map_en;
    end else if (bus_widx == IDX_W'(WI_CLK)) begin
      bus_rdata[DIV_W-1:0] = cfg.half_div;
    end else if (bus_widx == IDX_W'(WI_PHASE)) begin
      bus_rdata[B_OUTSEL] = cfg.out_sel;
      bus_rdata[B_COMPAT] = cfg.compat;
      bus_rdata[B_RXEN]   = cfg.rx_en;
    end else if (bus_widx == IDX_W'(WI_LEN)) begin
      bus_rdata[B_LEN +: LEN_W] = nbits_m1;
    end else if (bus_widx == IDX_W'(WI_HOLD)) begin
      bus_rdata[B_HOLD] = cfg.hold;
    end else if (bus_widx == IDX_W'(WI_CTL)) begin
      bus_rdata[B_SRST] = srst_busy_w;
      bus_rdata[B_MODE] = cfg.mode;
      bus_rdata[B_DONE] = done_w;
    end
  end
endmodule

// File: rtl/spi_user_engine_chk.sv
module spi_user_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic mmap_en,
  input logic busy,
  input logic done,
  input logic srst_busy
);
  // R4
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R8
  sclk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R9
  srst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (cs_n && !sclk && !mosi && !done));

  // R10
  mmap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mmap_en);

  // R6
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

bind spi_user_engine spi_user_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .cs_n(spi_cs_n), .mmap_en(mmap_en), .busy(busy_w), .done(done_w),
  .srst_busy(srst_busy_w)
);

// File: tb/spi_user_engine_tb.sv
module spi_user_engine_tb;
  localparam int IDX_W = 5;
  localparam int RSTC  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [4:0]  bus_widx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, mmap_en;

  always #5 clk = ~clk;

  spi_user_engine #(.IDX_W(IDX_W), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_widx(bus_widx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .mmap_en(mmap_en)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  // behavioural model state
  logic [7:0] mbuf [0:63];
  bit txb [0:511];
  bit rxb [0:511];
  bit m_busy, m_done, m_cs_n, m_out, m_rx, m_compat, m_hold, m_map, m_mode;
  int m_srst, m_t, m_div, m_len;

  function automatic logic [31:0] model_rd(input int idx);
    logic [31:0] r = '0;
    if (idx >= 16) r = {mbuf[4*(idx-16)+3], mbuf[4*(idx-16)+2], mbuf[4*(idx-16)+1], mbuf[4*(idx-16)]};
    else if (idx == 0)  r[18] = m_busy;
    else if (idx == 2)  r[17] = m_map;
    else if (idx == 6)  r[5:0] = 6'(m_div);
    else if (idx == 7)  begin r[27] = m_out; r[2] = m_compat; r[0] = m_rx; end
    else if (idx == 8)  r[25:17] = 9'(m_len);
    else if (idx == 11) r[30] = m_hold;
    else if (idx == 12) begin r[31] = (m_srst > 0); r[30] = m_mode; r[4] = m_done; end
    return r;
  endfunction

  always @(posedge clk) begin
    int wi, h, b;
    bit pb;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mbuf[i] = 8'h00;
      m_busy = 0; m_done = 1; m_cs_n = 1; m_out = 0; m_rx = 0; m_compat = 1;
      m_hold = 0; m_map = 1; m_mode = 0; m_srst = 0; m_t = 0; m_div = 1; m_len = 7;
    end else begin
      pb = m_busy;
      wi = int'(bus_widx);
      if (bus_we) begin
        if (wi == 12) begin
          m_mode = bus_wdata[30];
          if (!bus_wdata[4]) m_done = 0;
        end
        if (!pb) begin
          if (wi == 2) m_map = bus_wdata[17];
          if (wi == 6) m_div = int'(bus_wdata[5:0]);
          if (wi == 7) begin m_out = bus_wdata[27]; m_rx = bus_wdata[0]; m_compat = bus_wdata[2]; end
          if (wi == 8) m_len = int'(bus_wdata[25:17]);
          if (wi == 11) m_hold = bus_wdata[30];
          if (wi >= 16) for (int j = 0; j < 4; j++) mbuf[4*(wi-16)+j] = bus_wdata[8*j +: 8];
        end
      end
      h = m_div + 1;
      if (bus_we && wi == 12 && bus_wdata[31]) begin
        m_busy = 0; m_srst = RSTC; m_cs_n = 1; m_done = 0;
      end else if (m_srst > 0) begin
        m_srst--;
        if (m_srst == 0) m_done = 1;
      end else if (m_busy) begin
        m_t++;
        if (m_rx && (m_t % (2*h)) == h) begin
          b = m_t / (2*h);
          mbuf[b/8][7 - b%8] = rxb[b];
        end
        if (m_t == 2*h*(m_len+1)) begin
          m_busy = 0; m_done = 1; m_cs_n = !m_hold;
        end
      end else if (bus_we && wi == 0 && bus_wdata[18] && !m_done) begin
        if (m_out) begin
          m_busy = 1; m_t = 0; m_cs_n = 0;
          for (int k = 0; k < 512; k++) txb[k] = mbuf[k/8][7 - k%8];
        end else m_done = 1;
      end
    end
  end

  // per-clock comparison of pins, then slave drives MISO
  always @(negedge clk) begin
    int h;
    bit es, em;
    h = m_div + 1;
    if (rst_n) begin
      es = m_busy ? bit'((m_t / h) % 2) : 1'b0;
      em = m_busy ? txb[m_t / (2*h)] : 1'b0;
      vectors++;
      if (spi_sclk !== es || spi_mosi !== em || spi_cs_n !== m_cs_n || mmap_en !== (m_map && !m_busy)) begin
        fails++;
        $display("FAIL R3/R4/R8/R10 pins at cycle %0d: got sclk=%b mosi=%b cs_n=%b mmap=%b expected %b %b %b %b",
                 cyc, spi_sclk, spi_mosi, spi_cs_n, mmap_en, es, em, m_cs_n, m_map && !m_busy);
      end
    end
    spi_miso = m_busy ? rxb[m_t / (2*h)] : 1'b0;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      report();
    end
  end

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_widx = 5'(idx); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rchk(input int idx, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_widx = 5'(idx);
    #1;
    e = model_rd(idx);
    vectors++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s word %0d: got %h expected %h", req, idx, bus_rdata, e);
    end
  endtask

  task automatic pchk(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      bus_widx = 5'd12;
      #1;
      if (bus_rdata[4]) begin seen = 1; break; end
    end
    vectors++;
    if (!seen) begin
      fails++;
      $display("FAIL %s done poll: got 0 expected 1", req);
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_widx = '0; bus_wdata = '0; spi_miso = 1'b0;
    for (int i = 0; i < 512; i++) rxb[i] = ((i * 5) % 7) < 3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    pchk(spi_cs_n, 1'b1, "R1 cs_n");
    pchk(spi_sclk, 1'b0, "R1 sclk");
    pchk(spi_mosi, 1'b0, "R1 mosi");
    pchk(mmap_en, 1'b1, "R1 mmap_en");
    rchk(12, "R1"); rchk(0, "R1"); rchk(7, "R1"); rchk(6, "R1"); rchk(8, "R1");
    // R12 unimplemented words
    rchk(1, "R12"); rchk(4, "R12"); rchk(15, "R12");
    // R2 buffer fill and readback
    for (int w = 0; w < 16; w++) wr(16 + w, 32'h1357_9BDF ^ (w * 32'h0101_1111) ^ {w[7:0], 24'h00A5C3});
    for (int w = 0; w < 16; w++) rchk(16 + w, "R2");
    // transfer A: 16 bits, fastest clock, no capture, CS released (R3 R4 R5 R8)
    wr(7, 32'h0800_0000);
    wr(6, 0);
    wr(8, 15 << 17);
    wr(11, 0);
    wr(12, 0);
    wr(0, 1 << 18);
    wait_done("R3");
    pchk(spi_cs_n, 1'b1, "R8 release");
    rchk(16, "R5 unchanged"); rchk(7, "R12 compat");
    // transfer B: 12 bits, half period 3, capture on, CS held (R5 R8 R6)
    wr(7, 32'h0800_0001);
    wr(6, 2);
    wr(8, 11 << 17);
    wr(11, 1 << 30);
    wr(12, 0);
    wr(0, 1 << 18);
    wait_done("R6");
    pchk(spi_cs_n, 1'b0, "R8 hold");
    for (int w = 16; w < 19; w++) rchk(w, "R5");
    rchk(12, "R6");
    // R7: start with done still set is ignored
    wr(0, 1 << 18);
    repeat (6) @(negedge clk);
    pchk(spi_sclk, 1'b0, "R7 no sclk");
    rchk(0, "R7");
    // transfer C: full buffer, writes during busy dropped (R7 R10 R11)
    wr(12, 0);
    wr(11, 0);
    wr(6, 0);
    wr(8, 511 << 17);
    wr(0, 1 << 18);
    wr(16, 32'hDEAD_BEEF);
    wr(8, 0);
    wr(0, 1 << 18);
    rchk(0, "R7 busy");
    pchk(mmap_en, 1'b0, "R10 gated");
    wait_done("R3");
    rchk(8, "R11"); rchk(16, "R11");
    for (int w = 16; w < 32; w++) rchk(w, "R5");
    // output phase off: done on next edge, no clock (R3)
    wr(7, 32'h0000_0001);
    wr(12, 0);
    wr(0, 1 << 18);
    rchk(12, "R3 no phase");
    // soft reset mid transfer (R9)
    wr(7, 32'h0800_0001);
    wr(6, 1);
    wr(8, 100 << 17);
    wr(11, 1 << 30);
    wr(12, 0);
    wr(0, 1 << 18);
    repeat (23) @(negedge clk);
    wr(12, 32'h8000_0000);
    rchk(12, "R9 busy");
    pchk(spi_cs_n, 1'b1, "R9 cs_n");
    repeat (4) @(negedge clk);
    rchk(12, "R9 done");
    for (int w = 16; w < 20; w++) rchk(w, "R9 partial");
    // R6 write with bit4 set keeps done; R12 mode readback
    wr(12, 32'h4000_0010);
    rchk(12, "R6 keep");
    // R10 disable path
    wr(2, 0);
    @(negedge clk);
    pchk(mmap_en, 1'b0, "R10 disable");
    rchk(2, "R10");
    repeat (3) @(negedge clk);
    report();
  end
endmodule